// File: doc/BRIEF.md
# Shared-Prescaler Timer and Watchdog

This block pairs an 8-bit real-time counter with an 8-bit watchdog. A single binary prescaler serves both, but only one at a time. An 8-bit option register sets the behaviour. It chooses the counter's count source, which may be enabled instruction-cycle ticks or an edge on an external pin, and for the pin it chooses the active edge. It also controls whether the rollover interrupt is enabled, which counter receives the prescaler, and the prescaler's division select.

The same three-bit select gives a different ratio depending on where the prescaler is assigned. On the real-time counter the ratio runs from 1:2 to 1:256. On the watchdog it runs from 1:1 to 1:128. The counter that does not hold the prescaler counts every one of its source ticks. The watchdog counts a separate slow tick enable, and it keeps counting while the core is asleep. When it overflows it issues a one-cycle reset request and sets a sticky timeout status for the reset-cause logic. A clear strobe restarts the watchdog.

The watchdog is a three-state machine. `WDS_ARMED` counts with no timeout pending. `WDS_TRIP` lasts one cycle and drives the reset request. `WDS_EXPIRED` keeps counting with the timeout status held. The transitions are:

- overflow: `WDS_ARMED` to `WDS_TRIP`
- quiet trip exit: `WDS_TRIP` to `WDS_EXPIRED`
- re-overflow: `WDS_EXPIRED` to `WDS_TRIP`
- clear: any state to `WDS_ARMED`

Top module: `tick_watch_unit`

## Requirements
- R1: Reset leaves the following state. The real-time count is 0, the interrupt, reset request and timeout are low, and the option register holds 0xFF: external source, falling edge, prescaler on the watchdog at 1:128, interrupt disabled.
- R2: A write stores `opt_wdata` in the option register and clears the prescaler. The fields are bit 6 (interrupt disable), bit 5 (source: 1 = pin), bit 4 (pin edge: 1 = falling), bit 3 (assignment: 1 = watchdog) and bits [2:0] (division select). Bit 7 has no effect.
- R3: With bit 3 = 0, the real-time counter advances once per 2^(sel+1) source ticks, and the watchdog counts every slow tick.
- R4: With bit 3 = 1, the watchdog advances once per 2^sel slow ticks, and the real-time counter counts every source tick.
- R5: With bit 5 = 0, the source is `cyc_tick`, and it is ignored while `core_sleep` is high. With bit 5 = 1, `cyc_tick` is ignored.
- R6: With bit 5 = 1, the pin passes through two synchronizing flops. A rising (bit 4 = 0) or falling (bit 4 = 1) edge advances the counter on the third clock edge after the pin changes. The other edge direction is ignored.
- R7: The real-time count only ever steps by +1, wrapping from 0xFF to 0x00.
- R8: On a wrap with bit 6 = 0, `rtc_irq` is high for exactly the one cycle in which the count reads 0. With bit 6 = 1, it stays low.
- R9: The 256th watchdog advance after a restart raises `wdt_reset_req` for exactly one cycle, and counting restarts from 0.
- R10: `wdt_timeout` rises with the reset request and stays high until `wdt_clear`.
- R11: `wdt_clear` restarts the watchdog count and drops the timeout. It clears the prescaler only when bit 3 = 1.
- R12: The watchdog keeps counting slow ticks while `core_sleep` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_we | input | 1 | Option register write strobe |
| opt_wdata | input | 8 | Option register write data |
| cyc_tick | input | 1 | Instruction-cycle tick enable |
| core_sleep | input | 1 | Core is in power-down |
| tmr_pin | input | 1 | External count pin (asynchronous) |
| slow_tick | input | 1 | Watchdog slow oscillator tick enable |
| wdt_clear | input | 1 | Watchdog restart strobe |
| rtc_count | output | 8 | Real-time counter value |
| rtc_irq | output | 1 | One-cycle rollover interrupt request |
| wdt_reset_req | output | 1 | One-cycle watchdog reset request |
| wdt_timeout | output | 1 | Sticky watchdog timeout status |

## Verification
The bench builds the block with its default parameters: 8-bit counters, an 8-bit prescaler and two synchronizer stages. It drives the slow tick on every cycle, so a full 256-advance watchdog timeout fits in a few hundred cycles, and even the 1:2 watchdog ratio fits in about a thousand. The same defaults let the 1:256 counter ratio be reached in a few hundred instruction ticks. They also expose the off-by-one boundaries at 255 versus 256 advances and at 511 versus 512 prescaled ticks.

// File: rtl/twd_pkg.sv
package twd_pkg;

    localparam int CNT_W     = 8;
    localparam int PS_W      = 8;
    localparam int SEL_W     = 3;
    localparam logic [7:0] OPT_RESET = 8'hFF;

    typedef struct packed {
        logic             spare;
        logic             irq_off;
        logic             ext_src;
        logic             fall_edge;
        logic             to_wdt;
        logic [SEL_W-1:0] div_sel;
    } opt_t;

    typedef enum logic [1:0] {
        WDS_ARMED   = 2'd0,
        WDS_TRIP    = 2'd1,
        WDS_EXPIRED = 2'd2
    } wds_e;

endpackage

// File: rtl/twd_pin_edge.sv
module twd_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_pulse
);
    logic [SYNC_STAGES-1:0] stage;
    logic                   prev;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[g] <= 1'b0;
                    else        stage[g] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[g] <= 1'b0;
                    else        stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= stage[SYNC_STAGES-1];
    end

    always_comb begin
        if (fall_sel) edge_pulse = prev & ~stage[SYNC_STAGES-1];
        else          edge_pulse = stage[SYNC_STAGES-1] & ~prev;
    end
endmodule

// File: rtl/twd_prescaler.sv
module twd_prescaler #(
    parameter int PS_W  = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             in_tick,
    input  logic             to_wdt,
    input  logic [SEL_W-1:0] sel,
    output logic             out_tick
);
    localparam int LOG_W = $clog2(PS_W + 2);
    localparam logic [PS_W:0] ONE = 1;

    logic [PS_W-1:0] cnt;
    logic [LOG_W-1:0] shift_amt;
    logic [PS_W:0]   full_mask;
    logic [PS_W-1:0] mask;

    always_comb begin
        if (to_wdt) shift_amt = LOG_W'(sel);
        else        shift_amt = LOG_W'(sel) + LOG_W'(1);
        full_mask = (ONE << shift_amt) - ONE;
        mask      = full_mask[PS_W-1:0];
        out_tick  = in_tick && ((cnt & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (clr)     cnt <= '0;
        else if (in_tick) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/twd_rtc.sv
module twd_rtc #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             irq_off,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    localparam logic [CNT_W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= tick && (count == TOP) && !irq_off;
            if (tick) count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/twd_watchdog.sv
module twd_watchdog
    import twd_pkg::*;
#(
    parameter int WD_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clear,
    output logic reset_req,
    output logic timeout
);
    localparam logic [WD_W-1:0] TOP = '1;

    wds_e            state, state_nx;
    logic [WD_W-1:0] cnt;
    logic            wrap;

    assign wrap = tick && (cnt == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else if (tick)  cnt <= cnt + 1'b1;
    end

    always_comb begin
        state_nx = state;
        if (clear) begin
            state_nx = WDS_ARMED;
        end else begin
            unique case (state)
                WDS_ARMED:   if (wrap) state_nx = WDS_TRIP;
                WDS_TRIP:    state_nx = wrap ? WDS_TRIP : WDS_EXPIRED;
                WDS_EXPIRED: if (wrap) state_nx = WDS_TRIP;
                default:     state_nx = WDS_ARMED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WDS_ARMED;
        else        state <= state_nx;
    end

    always_comb begin
        reset_req = 1'b0;
        timeout   = 1'b0;
        unique case (state)
            WDS_ARMED:   ;
            WDS_TRIP:    begin reset_req = 1'b1; timeout = 1'b1; end
            WDS_EXPIRED: timeout = 1'b1;
            default:     ;
        endcase
    end
endmodule

// File: rtl/tick_watch_unit.sv
module tick_watch_unit
    import twd_pkg::*;
#(
    parameter int RTC_W       = twd_pkg::CNT_W,
    parameter int WD_W        = twd_pkg::CNT_W,
    parameter int PRE_W       = twd_pkg::PS_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             opt_we,
    input  logic [7:0]       opt_wdata,
    input  logic             cyc_tick,
    input  logic             core_sleep,
    input  logic             tmr_pin,
    input  logic             slow_tick,
    input  logic             wdt_clear,
    output logic [RTC_W-1:0] rtc_count,
    output logic             rtc_irq,
    output logic             wdt_reset_req,
    output logic             wdt_timeout
);
    opt_t opt_q;
    logic pin_edge, rtc_src, pre_in, pre_out, pre_clr, rtc_tick, wd_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      opt_q <= opt_t'(OPT_RESET);
        else if (opt_we) opt_q <= opt_t'(opt_wdata);
    end

    twd_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
        .clk(clk), .rst_n(rst_n), .pin(tmr_pin),
        .fall_sel(opt_q.fall_edge), .edge_pulse(pin_edge)
    );

    always_comb begin
        rtc_src  = opt_q.ext_src ? pin_edge : (cyc_tick & ~core_sleep);
        pre_in   = opt_q.to_wdt ? slow_tick : rtc_src;
        pre_clr  = opt_we | (wdt_clear & opt_q.to_wdt);
        rtc_tick = opt_q.to_wdt ? rtc_src : pre_out;
        wd_tick  = opt_q.to_wdt ? pre_out : slow_tick;
    end

    twd_prescaler #(.PS_W(PRE_W), .SEL_W(SEL_W)) i_pre (
        .clk(clk), .rst_n(rst_n), .clr(pre_clr), .in_tick(pre_in),
        .to_wdt(opt_q.to_wdt), .sel(opt_q.div_sel), .out_tick(pre_out)
    );

    twd_rtc #(.CNT_W(RTC_W)) i_rtc (
        .clk(clk), .rst_n(rst_n), .tick(rtc_tick), .irq_off(opt_q.irq_off),
        .count(rtc_count), .irq(rtc_irq)
    );

    twd_watchdog #(.WD_W(WD_W)) i_wdt (
        .clk(clk), .rst_n(rst_n), .tick(wd_tick), .clear(wdt_clear),
        .reset_req(wdt_reset_req), .timeout(wdt_timeout)
    );
endmodule

// File: rtl/twd_checker.sv
module twd_checker #(
    parameter int RTC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       opt_bits,
    input logic [RTC_W-1:0] rtc_count,
    input logic             rtc_irq,
    input logic             wdt_reset_req,
    input logic             wdt_timeout,
    input logic             wdt_clear
);
    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rtc_count) |-> rtc_count == RTC_W'($past(rtc_count) + 1'b1));

    assert_irq_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_irq |-> rtc_count == '0);

    assert_irq_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_irq |-> !$past(opt_bits[6]));

    assert_req_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset_req |=> !wdt_reset_req);

    assert_req_flags_timeout_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset_req |-> wdt_timeout);

    assert_timeout_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_timeout && !wdt_clear) |=> wdt_timeout);

    assert_clear_rearms_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clear |=> (!wdt_timeout && !wdt_reset_req));
endmodule

bind tick_watch_unit twd_checker #(.RTC_W(RTC_W)) i_twd_checker (
    .clk(clk), .rst_n(rst_n), .opt_bits(opt_q), .rtc_count(rtc_count),
    .rtc_irq(rtc_irq), .wdt_reset_req(wdt_reset_req),
    .wdt_timeout(wdt_timeout), .wdt_clear(wdt_clear)
);

// File: tb/test_tick_watch_unit.sv
`timescale 1ns/1ps
module test_tick_watch_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       opt_we = 1'b0;
    logic [7:0] opt_wdata = 8'h00;
    logic       cyc_tick = 1'b0, core_sleep = 1'b0, tmr_pin = 1'b0;
    logic       slow_tick = 1'b0, wdt_clear = 1'b0;
    logic [7:0] rtc_count;
    logic       rtc_irq, wdt_reset_req, wdt_timeout;

    int n_run = 0, n_fail = 0, irq_seen = 0, req_seen = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tick_watch_unit i_tick_watch_unit (
        .clk(clk), .rst_n(rst_n), .opt_we(opt_we), .opt_wdata(opt_wdata),
        .cyc_tick(cyc_tick), .core_sleep(core_sleep), .tmr_pin(tmr_pin),
        .slow_tick(slow_tick), .wdt_clear(wdt_clear), .rtc_count(rtc_count),
        .rtc_irq(rtc_irq), .wdt_reset_req(wdt_reset_req), .wdt_timeout(wdt_timeout)
    );

    // opt[31:24], tick count [23:8], expected count delta [7:0]
    localparam logic [31:0] VEC [7] = '{
        {8'h40, 16'd10,  8'd5},   // R3 1:2
        {8'h41, 16'd20,  8'd5},   // R3 1:4
        {8'h42, 16'd17,  8'd2},   // R3 1:8
        {8'h43, 16'd40,  8'd2},   // R3 1:16
        {8'h47, 16'd300, 8'd1},   // R3 1:256
        {8'h48, 16'd7,   8'd7},   // R4 counter undivided
        {8'h4F, 16'd9,   8'd9}    // R4 counter undivided
    };

    task automatic check(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    task automatic write_opt(logic [7:0] v);
        @(negedge clk); opt_wdata = v; opt_we = 1'b1;
        @(negedge clk); opt_we = 1'b0;
    endtask

    task automatic clear_wdt();
        @(negedge clk); wdt_clear = 1'b1;
        @(negedge clk); wdt_clear = 1'b0;
    endtask

    task automatic tick_cyc(int n);
        irq_seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); irq_seen += int'(rtc_irq); cyc_tick = 1'b1;
            @(negedge clk); irq_seen += int'(rtc_irq); cyc_tick = 1'b0;
        end
    endtask

    task automatic tick_slow(int n);
        req_seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); req_seen += int'(wdt_reset_req); slow_tick = 1'b1;
        end
        @(negedge clk); req_seen += int'(wdt_reset_req); slow_tick = 1'b0;
    endtask

    task automatic pin_step(logic v, int exp_delta, string tag);
        int base;
        base = int'(rtc_count);
        @(negedge clk); tmr_pin = v;
        @(negedge clk); @(negedge clk);
        check({tag, " before sync"}, int'(rtc_count), base);
        @(negedge clk);
        check(tag, int'(rtc_count), (base + exp_delta) % 256);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 count", int'(rtc_count), 0);
        check("R1 irq", int'(rtc_irq), 0);
        check("R1 req", int'(wdt_reset_req), 0);
        check("R1 timeout", int'(wdt_timeout), 0);
        // R1/R5: reset option selects pin source, so cycle ticks are ignored
        tick_cyc(3);
        check("R1 R5 cyc ignored", int'(rtc_count), 0);
        // R1/R6: falling edge selected at reset
        pin_step(1'b1, 0, "R6 rise ignored");
        pin_step(1'b0, 1, "R6 fall counted");

        // R2/R3/R4 vector walk
        foreach (VEC[k]) begin
            write_opt(VEC[k][31:24]);
            base = int'(rtc_count);
            tick_cyc(int'(VEC[k][23:8]));
            check($sformatf("R3 R4 vec %0d", k), (int'(rtc_count) - base + 256) % 256,
                  int'(VEC[k][7:0]));
        end

        // R2: a write clears the prescaler
        write_opt(8'h41);
        base = int'(rtc_count);
        tick_cyc(3);
        write_opt(8'h41);
        tick_cyc(1);
        check("R2 write clears prescaler", int'(rtc_count), base);

        // R5: sleep blocks cycle ticks
        write_opt(8'h48);
        base = int'(rtc_count);
        core_sleep = 1'b1;
        tick_cyc(5);
        core_sleep = 1'b0;
        check("R5 sleep blocks", int'(rtc_count), base);

        // R6: rising edge, pin source, undivided
        write_opt(8'h68);
        pin_step(1'b1, 1, "R6 rise counted");
        pin_step(1'b0, 0, "R6 fall ignored");
        base = int'(rtc_count);
        tick_cyc(4);
        check("R5 cyc ignored in pin mode", int'(rtc_count), base);

        // R7/R8: wrap with interrupt enabled
        write_opt(8'h08);
        tick_cyc((255 - int'(rtc_count)) % 256);
        check("R7 at top", int'(rtc_count), 255);
        check("R8 no early irq", irq_seen, 0);
        tick_cyc(1);
        check("R7 wrap", int'(rtc_count), 0);
        check("R8 irq pulse", int'(rtc_irq), 1);
        @(negedge clk);
        check("R8 irq one cycle", int'(rtc_irq), 0);
        // R8: interrupt disabled
        write_opt(8'h48);
        tick_cyc(256);
        check("R8 disabled count", int'(rtc_count), 0);
        check("R8 disabled irq", irq_seen, 0);

        // R9/R10: undivided watchdog
        write_opt(8'h40);
        clear_wdt();
        tick_slow(255);
        check("R9 255 no req", req_seen, 0);
        check("R10 no timeout", int'(wdt_timeout), 0);
        tick_slow(1);
        check("R9 256 req", req_seen, 1);
        check("R10 timeout set", int'(wdt_timeout), 1);
        @(negedge clk);
        check("R9 req one cycle", int'(wdt_reset_req), 0);
        tick_slow(10);
        check("R10 sticky", int'(wdt_timeout), 1);
        clear_wdt();
        check("R10 clear drops", int'(wdt_timeout), 0);

        // R11: clear restarts count
        tick_slow(200);
        clear_wdt();
        tick_slow(200);
        check("R11 restart no req", req_seen, 0);
        check("R11 restart timeout", int'(wdt_timeout), 0);

        // R4: watchdog 1:2
        write_opt(8'h49);
        clear_wdt();
        tick_slow(511);
        check("R4 511 no req", req_seen, 0);
        tick_slow(1);
        check("R4 512 req", req_seen, 1);

        // R11: clear also clears prescaler when on watchdog
        clear_wdt();
        tick_slow(1);
        clear_wdt();
        tick_slow(511);
        check("R11 prescaler cleared", req_seen, 0);
        tick_slow(1);
        check("R11 then req", req_seen, 1);
        clear_wdt();

        // R11: clear leaves prescaler alone when on counter
        write_opt(8'h40);
        base = int'(rtc_count);
        tick_cyc(1);
        clear_wdt();
        tick_cyc(1);
        check("R11 counter prescaler kept", (int'(rtc_count) - base + 256) % 256, 1);

        // R12: watchdog runs in sleep
        clear_wdt();
        core_sleep = 1'b1;
        tick_slow(256);
        core_sleep = 1'b0;
        check("R12 sleep req", req_seen, 1);
        check("R12 sleep timeout", int'(wdt_timeout), 1);

        finish_run();
    end
endmodule